// File: doc/BRIEF.md
# PCI interrupt line router

The router takes eight shared PCI interrupt request lines (PIRQ A to H, indices 0 to 7) and produces the levels of 24 interrupt lines. Lines 0 to 15 feed a legacy interrupt controller. Lines 16 to 23 feed an APIC. Each PIRQ has a route register that names one legacy line and carries a disable flag. A legacy line is the OR of every enabled PIRQ routed to it, so several PIRQs can share one legacy input. APIC line 16+n belongs to PIRQ n alone and ignores the route register.

A system control interrupt (SCI) input is registered and then ORed onto one runtime-selectable line. That line is one of five: 9, 10, 11, 20 or 21. The SCI can be moved while it is asserted. When that happens, the router leaves a one-cycle gap in which neither the old line nor the new line carries the SCI, and only then asserts the new line.

Software reaches the router through a single-cycle register write port. Addresses 0 to 7 hold the route bytes: PIRQ A to D at 0 to 3 and E to H at 4 to 7. Address 8 holds the SCI select byte. All line outputs are computed combinationally from the registered state and from the live PIRQ inputs.

Top module: `pirq_router`

## Requirements
- R1: A route byte at address n (n = 0..7, PIRQ A..H) uses bits [3:0] as the legacy line number and bit 7 as the disable flag; bits [6:4] are ignored.
- R2: After reset every route byte is 0x80 (disabled), the SCI line is 9 and the SCI is low, so with any PIRQ pattern lines 0..15 are all low.
- R3: Legacy line k (0..15) is high exactly when some PIRQ is high, enabled and routed to k; it follows a PIRQ input change in the same cycle, and several PIRQs may share one line.
- R4: A PIRQ whose route byte has bit 7 set drives no legacy line.
- R5: Line 16+n equals PIRQ n, whatever its route byte holds, apart from the SCI OR.
- R6: The SCI select byte sits at address 8, with the code in bits [2:0]: 0 selects line 9, 1 line 10, 2 line 11, 4 line 20 and 5 line 21.
- R7: A select write with the reserved codes 3, 6 or 7 leaves the SCI line unchanged.
- R8: sci_i is registered, and its level is ORed onto the selected line from the cycle after it is sampled.
- R9: A select write that changes the line while the SCI is high removes the SCI from both lines for the cycle after the write; the new line carries it from the following cycle. A write that selects the current line causes no gap.
- R10: A route write takes effect in the cycle after its clock edge; writes to addresses 9 to 15 change no route byte and no SCI line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address: 0-7 route bytes, 8 SCI select |
| wr_data_i | input | 8 | Write data |
| pirq_i | input | 8 | PIRQ A..H levels |
| sci_i | input | 1 | System control interrupt level |
| gsi_o | output | 24 | Interrupt line levels: 0-15 legacy, 16-23 APIC |

## Verification
The bench builds the router with its default parameters: eight PIRQs and sixteen legacy lines, which gives 24 lines and a 4-bit address. With these values both SCI groups exist, the legacy ones (9 to 11) and the APIC ones (20, 21), so migration between the groups and within a group can be exercised. The 4-bit route field reaches every legacy line, including line 15. Addresses 9 to 15 are left unused, so writes to them can be probed for having no effect.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned ROUTE_DIS_BIT = 7;
  localparam logic [7:0]  ROUTE_RST     = 8'h80;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned SCI_RST_LINE  = 9;

  typedef enum logic [SEL_W-1:0] {
    SEL_L9  = 3'd0,
    SEL_L10 = 3'd1,
    SEL_L11 = 3'd2,
    SEL_L20 = 3'd4,
    SEL_L21 = 3'd5
  } sci_sel_e;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned IRQ_W    = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [7:0]                         wr_data_i,
  output logic [NUM_PIRQ-1:0]                dis_o,
  output logic [NUM_PIRQ-1:0][IRQ_W-1:0]     irq_o
);

  logic unused_data;
  assign unused_data = ^wr_data_i[ROUTE_DIS_BIT-1:IRQ_W];

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dis_o[p] <= ROUTE_RST[ROUTE_DIS_BIT];
        irq_o[p] <= ROUTE_RST[IRQ_W-1:0];
      end else if (wr_en_i && wr_addr_i == ADDR_W'(p)) begin
        dis_o[p] <= wr_data_i[ROUTE_DIS_BIT];
        irq_o[p] <= wr_data_i[IRQ_W-1:0];
      end
    end
  end

  logic route_wr;
  assign route_wr = wr_en_i && (wr_addr_i < ADDR_W'(NUM_PIRQ));

  AST_ROUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_wr |=> ($stable(dis_o) && $stable(irq_o))); // R10

endmodule

// File: rtl/pirq_legacy_or.sv
module pirq_legacy_or #(
  parameter int unsigned NUM_PIRQ   = 8,
  parameter int unsigned NUM_LEGACY = 16,
  parameter int unsigned IRQ_W      = 4
) (
  input  logic [NUM_PIRQ-1:0]            pirq_i,
  input  logic [NUM_PIRQ-1:0]            dis_i,
  input  logic [NUM_PIRQ-1:0][IRQ_W-1:0] irq_i,
  output logic [NUM_LEGACY-1:0]          legacy_o
);

  for (genvar l = 0; l < NUM_LEGACY; l++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < NUM_PIRQ; p++) begin
        hit = hit | (pirq_i[p] & ~dis_i[p] & (irq_i[p] == IRQ_W'(l)));
      end
    end
    assign legacy_o[l] = hit;
  end

endmodule

// File: rtl/pirq_sci_ctrl.sv
module pirq_sci_ctrl
  import pirq_router_pkg::*;
#(
  parameter int unsigned LINE_W   = 5,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SCI_ADDR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              sci_i,
  output logic [LINE_W-1:0] line_o,
  output logic              drive_o
);

  logic              dec_ok;
  logic [LINE_W-1:0] dec_line;
  logic              sel_wr, upd;
  logic              lvl_q, gap_q;

  always_comb begin
    dec_ok   = 1'b1;
    dec_line = line_o;
    case (wr_sel_i)
      SEL_L9:  dec_line = LINE_W'(9);
      SEL_L10: dec_line = LINE_W'(10);
      SEL_L11: dec_line = LINE_W'(11);
      SEL_L20: dec_line = LINE_W'(20);
      SEL_L21: dec_line = LINE_W'(21);
      default: dec_ok   = 1'b0;
    endcase
  end

  assign sel_wr = wr_en_i && (wr_addr_i == ADDR_W'(SCI_ADDR));
  assign upd    = sel_wr && dec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o <= LINE_W'(SCI_RST_LINE);
      lvl_q  <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      lvl_q <= sci_i;
      // old line drops for one cycle before the new one rises
      gap_q <= upd && lvl_q && (dec_line != line_o);
      if (upd) line_o <= dec_line;
    end
  end

  assign drive_o = lvl_q & ~gap_q;

  AST_SCI_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o) && $past(lvl_q)) |-> !drive_o); // R9

  AST_SCI_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_W'(9) || line_o == LINE_W'(10) || line_o == LINE_W'(11) ||
     line_o == LINE_W'(20) || line_o == LINE_W'(21))); // R6

  AST_SCI_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr && !dec_ok) |=> $stable(line_o)); // R7

  AST_SCI_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> $past(sci_i)); // R8

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ   = 8,
  parameter int unsigned NUM_LEGACY = 16,
  localparam int unsigned NUM_GSI   = NUM_LEGACY + NUM_PIRQ,
  localparam int unsigned IRQ_W     = $clog2(NUM_LEGACY),
  localparam int unsigned LINE_W    = $clog2(NUM_GSI),
  localparam int unsigned SCI_ADDR  = NUM_PIRQ,
  localparam int unsigned ADDR_W    = $clog2(NUM_PIRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [NUM_PIRQ-1:0] pirq_i,
  input  logic               sci_i,
  output logic [NUM_GSI-1:0] gsi_o
);

  logic [NUM_PIRQ-1:0]            dis;
  logic [NUM_PIRQ-1:0][IRQ_W-1:0] irq;
  logic [NUM_LEGACY-1:0]          legacy;
  logic [LINE_W-1:0]              sci_line;
  logic                           sci_drive;

  pirq_route_regs #(
    .NUM_PIRQ (NUM_PIRQ),
    .IRQ_W    (IRQ_W),
    .ADDR_W   (ADDR_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .dis_o     (dis),
    .irq_o     (irq)
  );

  pirq_legacy_or #(
    .NUM_PIRQ   (NUM_PIRQ),
    .NUM_LEGACY (NUM_LEGACY),
    .IRQ_W      (IRQ_W)
  ) i_legacy (
    .pirq_i   (pirq_i),
    .dis_i    (dis),
    .irq_i    (irq),
    .legacy_o (legacy)
  );

  pirq_sci_ctrl #(
    .LINE_W   (LINE_W),
    .ADDR_W   (ADDR_W),
    .SCI_ADDR (SCI_ADDR)
  ) i_sci (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_sel_i  (wr_data_i[SEL_W-1:0]),
    .sci_i     (sci_i),
    .line_o    (sci_line),
    .drive_o   (sci_drive)
  );

  logic [NUM_GSI-1:0] base;
  assign base = {pirq_i, legacy};

  for (genvar g = 0; g < NUM_GSI; g++) begin : g_gsi
    assign gsi_o[g] = base[g] | (sci_drive & (sci_line == LINE_W'(g)));
  end

  AST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pirq_i == '0 && !sci_drive) |-> (gsi_o == '0)); // R3

endmodule

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  pirq_i = '0;
  logic        sci_i = 1'b0;
  logic [23:0] gsi_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pirq_router i_pirq_router (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pirq_i(pirq_i), .sci_i(sci_i), .gsi_o(gsi_o)
  );

  task automatic chk(input string req, input logic [23:0] exp);
    total++;
    if (gsi_o !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, gsi_o, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic set_pirq(input logic [7:0] v);
    pirq_i = v;
    #1;
  endtask

  task automatic next_cyc();
    @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    set_pirq(8'h00);
    chk("R2 idle", 24'h0);
    set_pirq(8'hFF);
    chk("R2 all disabled / R5 apic", 24'hFF0000);
    set_pirq(8'h00);
  endtask

  task automatic t_route();
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h05);
    wr(4'd4, 8'h0A);
    set_pirq(8'h01); chk("R3 A->5", 24'h010020);
    set_pirq(8'h02); chk("R3 B->5", 24'h020020);
    set_pirq(8'h03); chk("R3 shared 5", 24'h030020);
    set_pirq(8'h10); chk("R3 E->10", 24'h100400);
    set_pirq(8'h00); chk("R3 all low", 24'h0);
  endtask

  task automatic t_disable();
    wr(4'd0, 8'h85);
    set_pirq(8'h01); chk("R4 disabled A / R5", 24'h010000);
    wr(4'd0, 8'h0F);
    chk("R1 line 15", 24'h018000);
    set_pirq(8'h00);
  endtask

  task automatic t_fields();
    wr(4'd2, 8'h73);
    set_pirq(8'h04); chk("R1 bits 6:4 ignored", 24'h040008);
    wr(4'd12, 8'h02);
    chk("R10 unused address", 24'h040008);
    wr(4'd2, 8'h06);
    chk("R10 write visible next cycle", 24'h040040);
    set_pirq(8'h00);
  endtask

  task automatic t_sci_move();
    @(negedge clk_i); sci_i = 1'b1; #1;
    chk("R8 not yet registered", 24'h0);
    next_cyc(); chk("R8 reset line 9", 24'h000200);
    wr(4'd8, 8'h04); chk("R9 gap", 24'h0);
    next_cyc(); chk("R9 line 20 / R6", 24'h100000);
    wr(4'd8, 8'h03); chk("R7 reserved 3", 24'h100000);
    wr(4'd8, 8'h07); chk("R7 reserved 7", 24'h100000);
    wr(4'd12, 8'h05); chk("R10 unused address sci", 24'h100000);
    wr(4'd8, 8'h04); chk("R9 same line no gap", 24'h100000);
    wr(4'd8, 8'h05); chk("R9 gap 20->21", 24'h0);
    next_cyc(); chk("R6 line 21", 24'h200000);
    @(negedge clk_i); sci_i = 1'b0; #1;
    next_cyc(); chk("R8 sci low", 24'h0);
  endtask

  task automatic t_sci_legacy();
    wr(4'd8, 8'h01); chk("R9 no gap when low", 24'h0);
    @(negedge clk_i); sci_i = 1'b1; #1;
    next_cyc(); chk("R6 line 10", 24'h000400);
    wr(4'd8, 8'h02); chk("R9 gap 10->11", 24'h0);
    next_cyc(); chk("R6 line 11", 24'h000800);
    wr(4'd0, 8'h0B);
    set_pirq(8'h01); chk("R3 sci and pirq share 11", 24'h010800);
    @(negedge clk_i); sci_i = 1'b0; #1;
    next_cyc(); chk("R3 pirq holds 11", 24'h010800);
    wr(4'd8, 8'h06); chk("R7 reserved 6", 24'h010800);
    @(negedge clk_i); sci_i = 1'b1; set_pirq(8'h00);
    next_cyc(); chk("R7 line kept 11", 24'h000800);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_route();
    t_disable();
    t_fields();
    t_sci_move();
    t_sci_legacy();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule